// File: doc/BRIEF.md
# Packed AND-Test Mask Unit

This block is one execution slice of a vector unit. It receives two wide source operands, a per-element predicate and a small set of control fields. It splits both operands into elements of 8, 16, 32 or 64 bits over an active vector length of a quarter, half or the full operand width (128, 256 or 512 bits with the default width). For every element it reports one bit, which tells whether the two elements share any set bit. The bits are packed into a destination mask, one bit per element, starting at bit 0.

Predication zeroes the result bits of disabled elements and never keeps an old value. For 32- and 64-bit elements whose second source came from memory, a broadcast option tests the lowest element of source 2 against every element of source 1. The result is registered. A valid strobe follows each accepted operation by one clock. A sticky flag records any request for broadcast on a size that does not support it.

Top module: `vtest_mask_unit`

## Requirements
- R1: The number of active elements is the vector length divided by the element width. `esize` encodes 0=8, 1=16, 2=32 and 3=64 bits. `vlen` encodes 0=DATA_W/4, 1=DATA_W/2, and both 2 and 3=DATA_W bits. Element j occupies bits [j*w+w-1 : j*w] of each source.
- R2: Result bit j is 1 when element j of `src_a` AND element j of `src_b` has at least one bit set, and 0 when that AND is zero.
- R3: With `pred_en`=1, a result bit whose `pred` bit is 0 is written as 0. No previous mask value is kept.
- R4: With `pred_en`=0, the `pred` input has no effect on the result.
- R5: Mask bits from the active element count up to bit MASK_W-1 are always 0.
- R6: With `bcast`=1, `b_from_mem`=1 and 32- or 64-bit elements, bits [w-1:0] of `src_b` are tested against every element of `src_a`. With `b_from_mem`=0, the test is element by element.
- R7: With 8- or 16-bit elements, `bcast` is ignored and the test is element by element.
- R8: An accepted operation with `bcast`=1 and 8- or 16-bit elements sets `illegal_combo`. The flag stays set until reset. Broadcast on 32- or 64-bit elements never sets it.
- R9: Source bits above the active vector length do not affect any mask bit.
- R10: Operands are taken on a clock edge where `valid_in`=1. The new mask and a one-cycle `valid_out` pulse appear after that edge. Without `valid_in`, `valid_out` is 0 and `mask_out` holds its value.
- R11: Synchronous active-high `rst` clears `mask_out`, `valid_out` and `illegal_combo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Accept the operands on this edge |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| pred | input | MASK_W | Per-element predicate |
| pred_en | input | 1 | Enable zeroing predication |
| esize | input | 2 | Element width code |
| vlen | input | 2 | Vector length code |
| bcast | input | 1 | Broadcast request |
| b_from_mem | input | 1 | Second source came from memory |
| valid_out | output | 1 | Result strobe, one cycle per operation |
| mask_out | output | MASK_W | Destination mask |
| illegal_combo | output | 1 | Sticky broadcast-on-narrow-element flag |

## Verification
The AND test is driven with these patterns:
- Fully overlapping operands.
- Disjoint bit patterns that are non-zero on both sides but never meet.
- Sparse patterns where only some words or dwords meet.

Together these separate a true AND-reduction from an OR or a per-operand test. Each element width is combined with every vector length, so a wrong element count or a wrong reduction grouping shows up as misplaced or missing mask bits. Broadcast runs use a second source whose upper elements differ from its lowest one. A missing broadcast, and a broadcast that ignores the memory indication, can then be told apart. Directed runs then cover these cases:
- Ones above the vector length.
- Broadcast on byte elements, together with the sticky flag.
- Hold while idle.
- Reset in mid-stream.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
   typedef enum logic [1:0] {
      ES_B8  = 2'd0,
      ES_B16 = 2'd1,
      ES_B32 = 2'd2,
      ES_B64 = 2'd3
   } esize_e;

   typedef enum logic [1:0] {
      VL_QUARTER = 2'd0,
      VL_HALF    = 2'd1,
      VL_FULL    = 2'd2,
      VL_FULL_X  = 2'd3
   } vlen_e;

   // log2 of the active length relative to a quarter of the operand
   function automatic int unsigned vl_shift(input logic [1:0] code);
      case (code)
         VL_QUARTER: return 0;
         VL_HALF:    return 1;
         default:    return 2;
      endcase
   endfunction

   function automatic logic narrow_elem(input logic [1:0] code);
      return (code == ES_B8) || (code == ES_B16);
   endfunction
endpackage

// File: rtl/vtm_operand_prep.sv
module vtm_operand_prep
   import vtm_pkg::*;
#(
   parameter int unsigned DATA_W = 512
) (
   input  logic [DATA_W-1:0] src_b,
   input  logic [1:0]        esize,
   input  logic              bcast,
   input  logic              b_from_mem,
   output logic [DATA_W-1:0] b_eff
);
   localparam int unsigned NUM_QW = DATA_W / 64;

   if (DATA_W % 256 != 0) begin : g_bad_width
      $error("vtm_operand_prep: DATA_W must be a multiple of 256");
   end

   logic use_low;
   assign use_low = bcast && b_from_mem && !narrow_elem(esize);

   for (genvar g = 0; g < NUM_QW; g++) begin : g_qw
      logic [63:0] rep;
      always_comb begin
         if (esize == ES_B32) rep = {2{src_b[31:0]}};
         else                 rep = src_b[63:0];
      end
      assign b_eff[g*64 +: 64] = use_low ? rep : src_b[g*64 +: 64];
   end
endmodule

// File: rtl/vtm_lane_test.sv
module vtm_lane_test
   import vtm_pkg::*;
#(
   parameter int unsigned DATA_W = 512,
   localparam int unsigned MASK_W = DATA_W / 8
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        esize,
   output logic [MASK_W-1:0] elem_hit
);
   localparam int unsigned N_W = MASK_W / 2;
   localparam int unsigned N_D = MASK_W / 4;
   localparam int unsigned N_Q = MASK_W / 8;

   logic [MASK_W-1:0] hit_b;
   logic [N_W-1:0]    hit_w;
   logic [N_D-1:0]    hit_d;
   logic [N_Q-1:0]    hit_q;

   // byte-level reduction, wider sizes are OR trees of neighbours
   for (genvar i = 0; i < MASK_W; i++) begin : g_byte
      assign hit_b[i] = |(op_a[i*8 +: 8] & op_b[i*8 +: 8]);
   end
   for (genvar i = 0; i < N_W; i++) begin : g_word
      assign hit_w[i] = hit_b[2*i] | hit_b[2*i+1];
   end
   for (genvar i = 0; i < N_D; i++) begin : g_dword
      assign hit_d[i] = hit_w[2*i] | hit_w[2*i+1];
   end
   for (genvar i = 0; i < N_Q; i++) begin : g_qword
      assign hit_q[i] = hit_d[2*i] | hit_d[2*i+1];
   end

   always_comb begin
      elem_hit = '0;
      case (esize)
         ES_B8:   elem_hit = hit_b;
         ES_B16:  elem_hit[N_W-1:0] = hit_w;
         ES_B32:  elem_hit[N_D-1:0] = hit_d;
         default: elem_hit[N_Q-1:0] = hit_q;
      endcase
   end
endmodule

// File: rtl/vtm_mask_gate.sv
module vtm_mask_gate
   import vtm_pkg::*;
#(
   parameter int unsigned MASK_W = 64
) (
   input  logic [MASK_W-1:0] elem_hit,
   input  logic [MASK_W-1:0] pred,
   input  logic              pred_en,
   input  logic [1:0]        esize,
   input  logic [1:0]        vlen,
   output logic [MASK_W-1:0] mask_nxt
);
   localparam int unsigned CNT_W   = $clog2(MASK_W) + 2;
   localparam int unsigned BASE_KL = MASK_W / 4;

   if (MASK_W < 32) begin : g_bad_mask
      $error("vtm_mask_gate: MASK_W must be at least 32");
   end

   logic [CNT_W-1:0]  act_cnt;
   logic [MASK_W-1:0] live;
   logic [MASK_W-1:0] allow;

   always_comb begin
      act_cnt = CNT_W'((BASE_KL << vl_shift(vlen)) >> esize);
   end

   for (genvar j = 0; j < MASK_W; j++) begin : g_live
      assign live[j] = (CNT_W'(j) < act_cnt);
   end

   assign allow    = pred_en ? pred : '1;
   assign mask_nxt = elem_hit & live & allow;
endmodule

// File: rtl/vtest_mask_unit.sv
module vtest_mask_unit
   import vtm_pkg::*;
#(
   parameter int unsigned DATA_W = 512,
   localparam int unsigned MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [MASK_W-1:0] pred,
   input  logic              pred_en,
   input  logic [1:0]        esize,
   input  logic [1:0]        vlen,
   input  logic              bcast,
   input  logic              b_from_mem,
   output logic              valid_out,
   output logic [MASK_W-1:0] mask_out,
   output logic              illegal_combo
);
   logic [DATA_W-1:0] b_eff;
   logic [MASK_W-1:0] elem_hit;
   logic [MASK_W-1:0] mask_nxt;

   vtm_operand_prep #(.DATA_W(DATA_W)) u_prep (
      .src_b      (src_b),
      .esize      (esize),
      .bcast      (bcast),
      .b_from_mem (b_from_mem),
      .b_eff      (b_eff)
   );

   vtm_lane_test #(.DATA_W(DATA_W)) u_lanes (
      .op_a     (src_a),
      .op_b     (b_eff),
      .esize    (esize),
      .elem_hit (elem_hit)
   );

   vtm_mask_gate #(.MASK_W(MASK_W)) u_gate (
      .elem_hit (elem_hit),
      .pred     (pred),
      .pred_en  (pred_en),
      .esize    (esize),
      .vlen     (vlen),
      .mask_nxt (mask_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out     <= 1'b0;
         mask_out      <= '0;
         illegal_combo <= 1'b0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            mask_out <= mask_nxt;
            if (bcast && narrow_elem(esize)) illegal_combo <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/vtm_checker.sv
module vtm_checker #(
   parameter int unsigned DATA_W = 512,
   localparam int unsigned MASK_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_in,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [MASK_W-1:0] pred,
   input logic              pred_en,
   input logic [1:0]        esize,
   input logic [1:0]        vlen,
   input logic              bcast,
   input logic              b_from_mem,
   input logic              valid_out,
   input logic [MASK_W-1:0] mask_out,
   input logic              illegal_combo
);
   assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
   assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> (!valid_out && $stable(mask_out)));
   assert_zeroing_R3: assert property (@(posedge clk) disable iff (rst)
      (valid_in && pred_en) |=> ((mask_out & ~$past(pred)) == '0));
   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
      (valid_in && ((src_a & src_b) == '0) && !bcast) |=> (mask_out == '0));
   assert_upper_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (valid_in && esize == 2'd3) |=> (mask_out[MASK_W-1:MASK_W/8] == '0));
   assert_short_vl_R5: assert property (@(posedge clk) disable iff (rst)
      (valid_in && esize == 2'd3 && vlen == 2'd0)
         |=> (mask_out[MASK_W-1:MASK_W/32] == '0));
   assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
      (valid_in && bcast && esize[1] == 1'b0) |=> illegal_combo);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      illegal_combo |=> illegal_combo);
   assert_reset_R11: assert property (@(posedge clk)
      rst |=> (!valid_out && mask_out == '0 && !illegal_combo));
endmodule

bind vtest_mask_unit vtm_checker #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .valid_in      (valid_in),
   .src_a         (src_a),
   .src_b         (src_b),
   .pred          (pred),
   .pred_en       (pred_en),
   .esize         (esize),
   .vlen          (vlen),
   .bcast         (bcast),
   .b_from_mem    (b_from_mem),
   .valid_out     (valid_out),
   .mask_out      (mask_out),
   .illegal_combo (illegal_combo)
);

// File: tb/vtest_mask_unit_tb.sv
`timescale 1ns/1ps
module vtest_mask_unit_tb_top;
   localparam int unsigned DW = 512;
   localparam int unsigned MW = DW / 8;
   localparam int unsigned NVEC = 11;

   typedef struct packed {
      logic [31:0] tag;
      logic [63:0] a_pat;
      logic [63:0] b_pat;
      logic [63:0] b_alt;
      logic [63:0] prd;
      logic [1:0]  es;
      logic [1:0]  vl;
      logic        pen;
      logic        bc;
      logic        mem;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{"R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 64'h0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0},
      '{"R2", 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 64'hFF00_FF00_FF00_FF00, 64'h0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0},
      '{"R2", 64'h0000_0001_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0},
      '{"R1", 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0},
      '{"R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_AAAA_AAAA_AAAA, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0},
      '{"R4", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'h0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0},
      '{"R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0},
      '{"R6", 64'h0000_0010_0000_0010, 64'h0000_0000_0000_0010, 64'h0, 64'h0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1},
      '{"R6", 64'h0000_0010_0000_0010, 64'h0000_0000_0000_0010, 64'h0, 64'h0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0},
      '{"R6", 64'h0400_0000_0000_0000, 64'h0400_0000_0000_0000, 64'h0, 64'h0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1},
      '{"R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_0000_FF00_00FF, 64'h00FF_0000_FF00_00FF, 64'h0000_0000_0000_F0F3, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          valid_in = 1'b0;
   logic [DW-1:0] src_a = '0;
   logic [DW-1:0] src_b = '0;
   logic [MW-1:0] pred = '0;
   logic          pred_en = 1'b0;
   logic [1:0]    esize = 2'd0;
   logic [1:0]    vlen = 2'd0;
   logic          bcast = 1'b0;
   logic          b_from_mem = 1'b0;
   logic          valid_out;
   logic [MW-1:0] mask_out;
   logic          illegal_combo;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   vtest_mask_unit #(.DATA_W(DW)) dut_i (
      .clk           (clk),
      .rst           (rst),
      .valid_in      (valid_in),
      .src_a         (src_a),
      .src_b         (src_b),
      .pred          (pred),
      .pred_en       (pred_en),
      .esize         (esize),
      .vlen          (vlen),
      .bcast         (bcast),
      .b_from_mem    (b_from_mem),
      .valid_out     (valid_out),
      .mask_out      (mask_out),
      .illegal_combo (illegal_combo)
   );

   // Reference taken from the requirements: element loop over bits.
   function automatic logic [MW-1:0] ref_mask(
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [MW-1:0] p,
      input logic pen, input logic [1:0] es, input logic [1:0] vl,
      input logic bc, input logic mem);
      int ew;
      int vbits;
      int kl;
      logic low_only;
      logic hit;
      logic [MW-1:0] res;
      ew = 8 << es;
      vbits = (vl == 2'd0) ? DW / 4 : (vl == 2'd1) ? DW / 2 : DW;
      kl = vbits / ew;
      low_only = bc && mem && (es >= 2'd2);
      res = '0;
      for (int j = 0; j < kl; j++) begin
         hit = 1'b0;
         for (int k = 0; k < ew; k++)
            hit = hit | (a[j*ew + k] & b[low_only ? k : j*ew + k]);
         res[j] = hit && (!pen || p[j]);
      end
      return res;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [MW-1:0] got, input logic [MW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic run_op(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [MW-1:0] p, input logic pen, input logic [1:0] es,
                         input logic [1:0] vl, input logic bc, input logic mem);
      @(negedge clk);
      src_a = a; src_b = b; pred = p; pred_en = pen;
      esize = es; vlen = vl; bcast = bc; b_from_mem = mem;
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      check(req, "mask", mask_out, ref_mask(a, b, p, pen, es, vl, bc, mem));
      check("R10", "valid_out pulse", MW'(valid_out), MW'(1));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [MW-1:0] held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      check("R11", "mask after reset", mask_out, '0);
      check("R11", "valid after reset", MW'(valid_out), '0);
      check("R11", "flag after reset", MW'(illegal_combo), '0);

      for (int v = 0; v < NVEC; v++) begin
         run_op($sformatf("%s", VECS[v].tag), {8{VECS[v].a_pat}},
                {{7{VECS[v].b_alt}}, VECS[v].b_pat},
                {VECS[v].prd}, VECS[v].pen, VECS[v].es, VECS[v].vl,
                VECS[v].bc, VECS[v].mem);
      end
      // R8: wide-element broadcast never sets the flag
      check("R8", "flag after wide broadcast", MW'(illegal_combo), '0);

      // R9: ones above a quarter-length vector change nothing
      run_op("R9", {{(DW*3/4){1'b1}}, {(DW/4){1'b0}}}, '1, '0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
      check("R9", "upper source ignored", mask_out, '0);

      // R7: byte broadcast is ignored, element-wise result
      run_op("R7", '1, {{(DW-8){1'b1}}, 8'h00}, '0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1);
      check("R7", "byte broadcast ignored", mask_out, {{(MW-1){1'b1}}, 1'b0});
      check("R8", "flag raised", MW'(illegal_combo), MW'(1));

      // R8 sticky through a legal operation
      run_op("R4", '1, '1, '0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0);
      check("R8", "flag sticky", MW'(illegal_combo), MW'(1));

      // R10 hold while idle
      held = mask_out;
      repeat (3) @(negedge clk);
      check("R10", "valid low idle", MW'(valid_out), '0);
      check("R10", "mask held idle", mask_out, held);
      src_a = '0; src_b = '0;
      @(negedge clk);
      check("R10", "mask held with changed inputs", mask_out, held);

      // R11 reset in mid-stream
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11", "mask cleared", mask_out, '0);
      check("R11", "flag cleared", MW'(illegal_combo), '0);
      check("R11", "valid cleared", MW'(valid_out), '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule